// File: doc/BRIEF.md
# Dual-Channel Single/Dual-Slope PWM Timer

A 16-bit counter that steps once per enabled tick and drives two compare channels, A and B. A slope input selects single-slope counting (0 up to the limit, then wrap to 0) or dual-slope counting (0 up to the limit, then back down to 0). A 3-bit selector chooses where the upper count limit (TOP) comes from: one of three fixed widths, the active compare value of channel A, or a separately written limit register.

Each channel has a 2-bit output setting: off, toggle on match, non-inverting PWM or inverting PWM. Compare values pass through a write buffer and reach the active compare register only at a defined point in the count cycle, so a period that is already running is never disturbed. When channel A's compare value serves as TOP, channel A can only toggle and channel B carries the PWM. A one-clock overflow flag and one match flag per channel mark the counting events.

Top module: `pwm_timer`

## Requirements
- R1: While reset is asserted, both pins and all three flags are low. Reset sets the counter to 0 counting up and clears the compare buffers, the active compare values and the limit register.
- R2: With `dual_slope`=0 the counter steps only on clocks with `tick` high. It goes from 0 up to TOP and then wraps to 0, so a period is TOP+1 ticks. `ovf_flag` pulses once per period, as the counter wraps to 0.
- R3: `top_src` codes 0, 1 and 2 give TOP = 255, 511 and 1023. Code 3 takes TOP from channel A's active compare value. Code 4 takes TOP from the limit register. Codes 5 to 7 behave like code 0.
- R4: With `dual_slope`=1 the counter runs from 0 up to TOP and back down to 0, so a period is 2*TOP ticks. `ovf_flag` pulses as the counter arrives at 0.
- R5: Output setting 2'b10 is non-inverting PWM. In single slope the pin is high for the first C counts of the period (C = compare value) and high for the whole period when C >= TOP. In dual slope the pin clears on an up-counting match and sets on a down-counting match, so it is high for 2*C of 2*TOP ticks. C = 0 gives a constant low.
- R6: Setting 2'b11 outputs the complement of the 2'b10 waveform. Setting 2'b00 holds the pin low.
- R7: Setting 2'b01 inverts the pin once on every match (count equal to compare value). The channel's match flag pulses once per match. A dual-slope period with 0 < C < TOP holds two matches.
- R8: With `top_src`=3, channel A produces no PWM: settings 2'b10 and 2'b11 hold `pin_a` low. Setting 2'b01 toggles `pin_a` once per period, at TOP, which gives a 50% duty at twice the counter period. Channel B still produces PWM.
- R9: With `top_src`=4, channels A and B each set their own duty from their own compare value.
- R10: A write with `wr_sel` 0 or 1 lands in the buffer of channel A or B. A write with `wr_sel` 2 loads the limit register. A write with `wr_sel` 3 changes nothing. A buffer is copied into the active compare value as the counter wraps to 0 in single slope, or as it arrives at TOP in dual slope. A write never changes the waveform before that point.
- R11: `ovf_flag` is high for one clock per event, even when `tick` is high on only some clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count enable |
| dual_slope | input | 1 | 0 single-slope, 1 dual-slope |
| top_src | input | 3 | Source of the count limit |
| out_mode_a | input | 2 | Channel A output setting |
| out_mode_b | input | 2 | Channel B output setting |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 A buffer, 1 B buffer, 2 limit, 3 none |
| wr_data | input | 16 | Write data |
| pin_a | output | 1 | Channel A pin |
| pin_b | output | 1 | Channel B pin |
| ovf_flag | output | 1 | Overflow event pulse |
| match_a_flag | output | 1 | Channel A match pulse |
| match_b_flag | output | 1 | Channel B match pulse |

## Verification
Duty is measured by counting high pins over one ovf-aligned period. Compare values of 0, mid-range and TOP are used, with both slopes, so that the constant-output ends can be told apart from an off-by-one in the level comparison. Periods are measured for each TOP source and with a half-rate tick, which separates a wrong limit from counting on non-tick clocks. A write made early in a dual-slope period yields 50 high counts only if the buffer copies at TOP; copying at BOTTOM would give 40, and copying at once would give 60. Channel A is also run as TOP, where toggle mode must give a 50% wave and PWM settings must stay low.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {OUT_OFF = 2'b00, OUT_TOG = 2'b01, OUT_NINV = 2'b10, OUT_INV = 2'b11} out_mode_e;

  localparam logic [2:0] TOP_FIX8  = 3'd0;
  localparam logic [2:0] TOP_FIX9  = 3'd1;
  localparam logic [2:0] TOP_FIX10 = 3'd2;
  localparam logic [2:0] TOP_CMPA  = 3'd3;
  localparam logic [2:0] TOP_LIMIT = 3'd4;

  localparam logic [1:0] SEL_A     = 2'd0;
  localparam logic [1:0] SEL_B     = 2'd1;
  localparam logic [1:0] SEL_LIMIT = 2'd2;

  // fixed count limits for the width-based selectors
  function automatic logic [31:0] fixed_top(input logic [2:0] sel);
    case (sel)
      TOP_FIX9:  return 32'd511;
      TOP_FIX10: return 32'd1023;
      default:   return 32'd255;
    endcase
  endfunction

  // non-inverting PWM level for a given counter state
  function automatic logic pwm_high(input logic dual, input logic down,
                                    input logic [31:0] cnt, input logic [31:0] cmp,
                                    input logic [31:0] top);
    if (!dual) return (cmp >= top) || (cnt < cmp);
    if (down) return cnt <= cmp;
    return cnt < cmp;
  endfunction
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         dual,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         down,
  output logic         evt_ovf,
  output logic         evt_upd
);
  logic [W-1:0] cnt_q, cnt_n;
  logic         down_q, down_n;
  logic [W:0]   cnt_inc;
  logic         at_top, at_bot;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
    if (dual) at_top = !down_q && (cnt_inc >= {1'b0, top});
    else      at_top = cnt_q >= top;
    at_bot = dual && down_q && (cnt_q <= W'(1));
    cnt_n  = cnt_q;
    down_n = down_q;
    if (!dual) begin
      down_n = 1'b0;
      cnt_n  = at_top ? '0 : cnt_inc[W-1:0];
    end else if (at_top) begin
      cnt_n  = top;
      down_n = 1'b1;
    end else if (at_bot) begin
      cnt_n  = '0;
      down_n = 1'b0;
    end else if (down_q) begin
      cnt_n = cnt_q - W'(1);
    end else begin
      cnt_n = cnt_inc[W-1:0];
    end
  end

  assign evt_upd = tick && at_top;
  assign evt_ovf = tick && (dual ? at_bot : at_top);
  assign cnt     = cnt_q;
  assign down    = down_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= cnt_n;
      down_q <= down_n;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= top) |=> ((cnt_q <= top) || !$stable(top))); // R2 R4
endmodule

// File: rtl/pwm_cmp_buf.sv
module pwm_cmp_buf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         upd,
  output logic [W-1:0] active
);
  logic [W-1:0] buf_q, act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr)  buf_q <= wdata;
      if (upd) act_q <= buf_q;
    end
  end

  assign active = act_q;

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(act_q)); // R10
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              dual,
  input  logic              down,
  input  logic [W-1:0]      cnt,
  input  logic [W-1:0]      top,
  input  logic [W-1:0]      cmp,
  input  pwm_pkg::out_mode_e mode,
  input  logic              hold_pwm,
  output logic              pin,
  output logic              match
);
  import pwm_pkg::*;

  logic tog_q, tog_n, level, pin_q, pin_n;

  assign match = tick && (cnt == cmp);
  assign tog_n = tog_q ^ match;
  assign level = pwm_high(dual, down, 32'(cnt), 32'(cmp), 32'(top));

  always_comb begin
    case (mode)
      OUT_OFF:  pin_n = 1'b0;
      OUT_TOG:  pin_n = tog_n;
      OUT_NINV: pin_n = !hold_pwm && level;
      OUT_INV:  pin_n = !hold_pwm && !level;
      default:  pin_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      tog_q <= tog_n;
      pin_q <= pin_n;
    end
  end

  assign pin = pin_q;

  AST_PIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OUT_OFF) |=> !pin_q); // R6
  AST_ATOP_NO_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_pwm && mode[1]) |=> !pin_q); // R8
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (match && mode == OUT_TOG && $stable(mode)) |=> (pin_q != $past(pin_q))); // R7
  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_pwm && mode == OUT_NINV && cmp == '0 && top != '0 && !down) |=> !pin_q); // R5
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         dual_slope,
  input  logic [2:0]   top_src,
  input  logic [1:0]   out_mode_a,
  input  logic [1:0]   out_mode_b,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic         pin_a,
  output logic         pin_b,
  output logic         ovf_flag,
  output logic         match_a_flag,
  output logic         match_b_flag
);
  import pwm_pkg::*;

  localparam int NCH = 2;

  logic [W-1:0] limit_q, top_w;
  logic [W-1:0] cnt;
  logic         down, evt_ovf, evt_upd, a_is_top;
  logic [W-1:0] cmp_act [NCH];
  logic [NCH-1:0] pin_v, match_v;
  logic [1:0]   mode_v [NCH];
  logic         ovf_q, mta_q, mtb_q;

  assign mode_v[0] = out_mode_a;
  assign mode_v[1] = out_mode_b;
  assign a_is_top  = (top_src == TOP_CMPA);

  always_comb begin
    case (top_src)
      TOP_CMPA:  top_w = cmp_act[0];
      TOP_LIMIT: top_w = limit_q;
      default:   top_w = W'(fixed_top(top_src));
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) limit_q <= '0;
    else if (wr_en && wr_sel == SEL_LIMIT) limit_q <= wr_data;
  end

  pwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dual(dual_slope), .top(top_w),
    .cnt(cnt), .down(down), .evt_ovf(evt_ovf), .evt_upd(evt_upd)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pwm_cmp_buf #(.W(W)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .wr(wr_en && wr_sel == 2'(ch)), .wdata(wr_data),
      .upd(evt_upd), .active(cmp_act[ch])
    );
    pwm_chan #(.W(W)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick), .dual(dual_slope), .down(down),
      .cnt(cnt), .top(top_w), .cmp(cmp_act[ch]), .mode(out_mode_e'(mode_v[ch])),
      .hold_pwm((ch == 0) && a_is_top), .pin(pin_v[ch]), .match(match_v[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      mta_q <= 1'b0;
      mtb_q <= 1'b0;
    end else begin
      ovf_q <= evt_ovf;
      mta_q <= match_v[0];
      mtb_q <= match_v[1];
    end
  end

  assign pin_a        = pin_v[0];
  assign pin_b        = pin_v[1];
  assign ovf_flag     = ovf_q;
  assign match_a_flag = mta_q;
  assign match_b_flag = mtb_q;

  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && top_w > W'(1)) |=> !ovf_q); // R11
endmodule

// File: tb/pwm_timer_test.sv
module pwm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        half_rate = 1'b0;
  logic        dual_s = 1'b0;
  logic [2:0]  src = 3'd0;
  logic [1:0]  ma = 2'b00, mb = 2'b00;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        pin_a, pin_b, ovf_flag, match_a_flag, match_b_flag;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  always @(negedge clk) tick <= half_rate ? ~tick : 1'b1;

  pwm_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dual_slope(dual_s), .top_src(src),
    .out_mode_a(ma), .out_mode_b(mb), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pin_a(pin_a), .pin_b(pin_b), .ovf_flag(ovf_flag),
    .match_a_flag(match_a_flag), .match_b_flag(match_b_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic prep(input logic d, input logic [2:0] s, input logic [1:0] a, input logic [1:0] b);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    dual_s = d; src = s; ma = a; mb = b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wreg(input logic [1:0] s, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ovf();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ovf_flag && n < 5000);
    if (!ovf_flag) chk("R2 overflow timeout", 0, 1);
  endtask

  task automatic settle();
    wait_ovf();
    wait_ovf();
  endtask

  task automatic period(output int p);
    wait_ovf();
    p = 0;
    do begin
      @(negedge clk);
      p++;
    end while (!ovf_flag && p < 5000);
  endtask

  task automatic window(input int n, output int hia, output int hib, output int mtb);
    wait_ovf();
    hia = 0; hib = 0; mtb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hia += int'(pin_a);
      hib += int'(pin_b);
      mtb += int'(match_b_flag);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", int'({pin_a, pin_b, ovf_flag, match_a_flag, match_b_flag}), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_fixed();
    int p;
    prep(1'b0, 3'd0, 2'b00, 2'b00); period(p); chk("R3 R2 fixed 8-bit period", p, 256);
    prep(1'b0, 3'd1, 2'b00, 2'b00); period(p); chk("R3 fixed 9-bit period", p, 512);
    prep(1'b0, 3'd2, 2'b00, 2'b00); period(p); chk("R3 fixed 10-bit period", p, 1024);
    prep(1'b0, 3'd5, 2'b00, 2'b00); period(p); chk("R3 code 5 period", p, 256);
  endtask

  task automatic t_prescale();
    int p;
    prep(1'b0, 3'd0, 2'b00, 2'b00);
    half_rate = 1'b1;
    settle();
    period(p); chk("R2 half-rate tick period", p, 512);
    wait_ovf();
    @(negedge clk);
    chk("R11 ovf flag one clock", int'(ovf_flag), 0);
    half_rate = 1'b0;
  endtask

  task automatic t_single();
    int p, ha, hb, mt;
    prep(1'b0, 3'd4, 2'b11, 2'b10);
    wreg(2'd2, 99); wreg(2'd1, 30); wreg(2'd0, 70);
    settle();
    period(p); chk("R9 R2 limit period", p, 100);
    window(100, ha, hb, mt);
    chk("R5 R9 single ninv duty", hb, 30);
    chk("R6 R9 single inv duty", ha, 30);
    chk("R7 single match count", mt, 1);
    wreg(2'd1, 0); settle(); window(100, ha, hb, mt);
    chk("R5 single compare 0", hb, 0);
    wreg(2'd1, 99); settle(); window(100, ha, hb, mt);
    chk("R5 single compare TOP", hb, 100);
    ma = 2'b00; settle(); window(100, ha, hb, mt);
    chk("R6 disconnected low", ha, 0);
    wreg(2'd3, 7); settle();
    period(p); chk("R10 select 3 period", p, 100);
    window(100, ha, hb, mt); chk("R10 select 3 duty", hb, 100);
  endtask

  task automatic t_dual();
    int p, ha, hb, mt;
    prep(1'b1, 3'd4, 2'b11, 2'b10);
    wreg(2'd2, 50); wreg(2'd1, 20); wreg(2'd0, 20);
    settle();
    period(p); chk("R4 dual period", p, 100);
    window(100, ha, hb, mt);
    chk("R5 dual ninv duty", hb, 40);
    chk("R6 dual inv duty", ha, 60);
    chk("R7 dual match count", mt, 2);
    wreg(2'd1, 50); settle(); window(100, ha, hb, mt);
    chk("R5 dual compare TOP", hb, 100);
    wreg(2'd1, 0); settle(); window(100, ha, hb, mt);
    chk("R5 dual compare 0", hb, 0);
  endtask

  task automatic t_toggle();
    int ha, hb, mt;
    prep(1'b0, 3'd4, 2'b00, 2'b01);
    wreg(2'd2, 99); wreg(2'd1, 10);
    settle();
    window(200, ha, hb, mt);
    chk("R7 toggle duty", hb, 100);
    chk("R7 toggle matches", mt, 2);
  endtask

  task automatic t_a_top();
    int p, ha, hb, mt;
    prep(1'b1, 3'd3, 2'b01, 2'b10);
    wreg(2'd0, 40); wreg(2'd1, 10);
    settle();
    period(p); chk("R8 R3 A as TOP period", p, 80);
    window(160, ha, hb, mt);
    chk("R8 A toggle half duty", ha, 80);
    chk("R8 B pwm with A as TOP", hb, 40);
    ma = 2'b10; settle(); window(80, ha, hb, mt);
    chk("R8 A pwm setting held low", ha, 0);
  endtask

  task automatic t_buffer();
    int hi;
    prep(1'b0, 3'd4, 2'b00, 2'b10);
    wreg(2'd2, 99); wreg(2'd1, 30);
    settle();
    wait_ovf();
    hi = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      hi += int'(pin_b);
      if (i == 5) begin wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd60; end
      if (i == 6) wr_en = 1'b0;
    end
    chk("R10 single period unchanged", hi, 30);
    hi = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      hi += int'(pin_b);
    end
    chk("R10 single next period", hi, 60);
    prep(1'b1, 3'd4, 2'b00, 2'b10);
    wreg(2'd2, 50); wreg(2'd1, 20);
    settle();
    wait_ovf();
    hi = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      hi += int'(pin_b);
      if (i == 5) begin wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd30; end
      if (i == 6) wr_en = 1'b0;
    end
    chk("R10 dual update at TOP", hi, 50);
  endtask

  initial begin
    t_reset();
    t_fixed();
    t_prescale();
    t_single();
    t_dual();
    t_toggle();
    t_a_top();
    t_buffer();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule